// File: doc/BRIEF.md
# Multi-core power sequencing unit

This block governs the supply of a small cluster of CPU cores (four by default). Each core has a power-enable output and a wait-for-interrupt input. Software uses a 32-bit memory-mapped register port to bring a powered-down core back up, and to arm a running core so that it drops into standby the next time it signals WFI. Switching power in either direction takes a modelled delay of `DLY` cycles, which a per-core countdown sets.

A wake request is a one-hot bit in the wake register. Hardware clears that bit once the core is running again, so software can poll the register until it reads zero. The power-down request is only an arming value, and nothing happens until the core's WFI input is seen. The state of every core can be read as a packed status word with one nibble per core. A 32-bit debug reset-enable register is provided as plain storage that software updates with read-modify-write.

Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_en` with `bus_we` low, and is zero otherwise. Writes take effect at the rising edge where `bus_en` and `bus_we` are both high.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, core 0 is powered (`core_pwr_en[0]`=1, status code 0) and every other core is unpowered (enable 0, status code 3). The wake register, every core mode register and the debug register read 0.
- R2: Writing a one to bit n of the wake register (offset 0x10) for an unpowered core raises `core_pwr_en[n]` at the 17th rising edge after the write edge (DLY=16). Bit n reads 1 until that edge and 0 from that edge on.
- R3: A wake bit written for a core that is already powered reads 1 after the write edge and 0 after the next edge. The core's enable does not change.
- R4: A write of zeros to the wake register does not cancel a pending request. The pending bit still reads 1, and the power-up completes at its original edge.
- R5: The mode register of core n sits at offset 0x100 + 0x10·n. It stores bits [1:0] of the written data, which read back in bits [1:0] with all other bits zero. The value 3 arms the core for standby.
- R6: When an armed, powered core has its WFI input high at a rising edge, its enable stays high for 15 more edges and falls at the 16th edge after the WFI edge. At that edge its status code becomes 3 and its mode register becomes 0.
- R7: WFI has no effect on a core whose mode register is not 3, and none on an unpowered core. Its enable keeps its value, and an armed but unpowered core keeps mode 3.
- R8: The status register (offset 0x40) holds core n's two-bit code at bits [4n+1:4n] and zeros in every other bit. The code is 0 while the core is powered, including its power-down countdown. It is 3 while the core is unpowered, including its power-up countdown.
- R9: A wake request written during a core's power-down countdown is held. The core still reaches standby at the normal edge, then powers back up: its enable rises at the 17th edge after it fell, and the wake bit clears at that edge.
- R10: The debug register (offset 0x180) stores all 32 written bits and reads them back unchanged, so read-modify-write of its individual enable bits works.
- R11: Every offset other than 0x10, 0x40, 0x180 and 0x100 + 0x10·n (n < cores) reads as zero. Writes to such offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| core_wfi | input | NCORES (4) | Wait-for-interrupt indication per core |
| core_pwr_en | output | NCORES (4) | Power enable per core |

## Verification
The overlap that matters is a wake request that lands while the same core is still counting down into standby. Two things then hold at once: the request stays pending and the power-down continues. The bench arms the core, pulses WFI, writes the wake bit five cycles later, and checks three things. The enable must still fall exactly 16 edges after WFI, with the wake bit still set. It must stay low through the next 16 edges. It must rise on the 17th, with the wake bit cleared on that same edge. The bench also makes a zero write to the wake register in the middle of a power-up, to show that a write cannot cancel a request that is already pending.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_DOWN = 2'd1,
    PS_STBY = 2'd2,
    PS_UP   = 2'd3
  } pwr_state_e;

  localparam logic [1:0] CODE_ON   = 2'd0;
  localparam logic [1:0] CODE_OFF  = 2'd3;
  localparam logic [1:0] MODE_ARM  = 2'd3;

  localparam logic [11:0] OFS_WAKE  = 12'h010;
  localparam logic [11:0] OFS_STAT  = 12'h040;
  localparam logic [11:0] OFS_CORE0 = 12'h100;
  localparam logic [11:0] OFS_CSTEP = 12'h010;
  localparam logic [11:0] OFS_DBG   = 12'h180;

endpackage

// File: rtl/core_pwr_unit.sv
module core_pwr_unit
  import core_pwr_pkg::*;
#(
  parameter int DLY      = 16,
  parameter bit RESET_ON = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_wdata,
  output logic [1:0] mode_q,
  input  logic       wfi,
  input  logic       wake_pend,
  output logic       wake_clr,
  output logic       pwr_en,
  output logic [1:0] st_code
);

  localparam int            CW       = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(DLY - 1);

  pwr_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    mode_d;
  logic          upd_en;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    wake_clr = 1'b0;
    case (st_q)
      PS_RUN: begin
        if (wake_pend) wake_clr = 1'b1;
        if (mode_q == MODE_ARM && wfi) begin
          st_d  = PS_DOWN;
          cnt_d = CNT_LOAD;
        end
      end
      PS_DOWN: begin
        if (cnt_q == '0) begin
          st_d   = PS_STBY;
          mode_d = 2'd0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PS_STBY: begin
        if (wake_pend) begin
          st_d  = PS_UP;
          cnt_d = CNT_LOAD;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          st_d     = PS_RUN;
          wake_clr = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
    if (mode_we) mode_d = mode_wdata;
  end

  assign upd_en = (st_d != st_q) || (cnt_d != cnt_q) || (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RESET_ON ? PS_RUN : PS_STBY;
      cnt_q  <= '0;
      mode_q <= 2'd0;
    end else if (upd_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign pwr_en  = (st_q == PS_RUN) || (st_q == PS_DOWN);
  assign st_code = pwr_en ? CODE_ON : CODE_OFF;

endmodule

// File: rtl/core_pwr_regs.sv
module core_pwr_regs
  import core_pwr_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int AW     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NCORES-1:0]     wake_clr,
  input  logic [2*NCORES-1:0]   code_flat,
  input  logic [2*NCORES-1:0]   mode_flat,
  output logic [NCORES-1:0]     wake_q,
  output logic [31:0]           dbg_q,
  output logic [NCORES-1:0]     mode_we
);

  logic                sel_wake, sel_stat, sel_dbg, wr, rd;
  logic [NCORES-1:0]   sel_core;
  logic [NCORES-1:0]   wake_set, wake_d;
  logic                wake_en, dbg_en;
  logic [31:0]         stat_word;

  assign wr       = bus_en &  bus_we;
  assign rd       = bus_en & ~bus_we;
  assign sel_wake = (bus_addr == AW'(OFS_WAKE));
  assign sel_stat = (bus_addr == AW'(OFS_STAT));
  assign sel_dbg  = (bus_addr == AW'(OFS_DBG));

  for (genvar i = 0; i < NCORES; i++) begin : g_dec
    assign sel_core[i] = (bus_addr == AW'(OFS_CORE0 + 12'(i) * OFS_CSTEP));
    assign mode_we[i]  = wr & sel_core[i];
  end

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NCORES; i++) stat_word[4*i +: 2] = code_flat[2*i +: 2];
  end

  // wake register: new ones are OR-ed in, completions clear
  assign wake_set = (wr && sel_wake) ? bus_wdata[NCORES-1:0] : '0;
  assign wake_d   = (wake_q & ~wake_clr) | wake_set;
  assign wake_en  = (wr && sel_wake) || (|(wake_q & wake_clr));
  assign dbg_en   = wr && sel_dbg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_q <= '0;
    else if (wake_en) wake_q <= wake_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dbg_q <= '0;
    else if (dbg_en) dbg_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (sel_wake)      bus_rdata = 32'(wake_q);
      else if (sel_stat) bus_rdata = stat_word;
      else if (sel_dbg)  bus_rdata = dbg_q;
      else begin
        for (int i = 0; i < NCORES; i++)
          if (sel_core[i]) bus_rdata = {30'd0, mode_flat[2*i +: 2]};
      end
    end
  end

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import core_pwr_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int AW     = 12,
  parameter int DLY    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCORES-1:0] core_wfi,
  output logic [NCORES-1:0] core_pwr_en
);

  logic [1:0]          rst_sync;
  logic                rst_sync_n;
  logic [NCORES-1:0]   wake_q, wake_clr, mode_we;
  logic [2*NCORES-1:0] code_flat, mode_flat;
  logic [31:0]         dbg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  core_pwr_regs #(.NCORES(NCORES), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wake_clr  (wake_clr),
    .code_flat (code_flat),
    .mode_flat (mode_flat),
    .wake_q    (wake_q),
    .dbg_q     (dbg_q),
    .mode_we   (mode_we)
  );

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    core_pwr_unit #(.DLY(DLY), .RESET_ON(i == 0)) u_unit (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .mode_we    (mode_we[i]),
      .mode_wdata (bus_wdata[1:0]),
      .mode_q     (mode_flat[2*i +: 2]),
      .wfi        (core_wfi[i]),
      .wake_pend  (wake_q[i]),
      .wake_clr   (wake_clr[i]),
      .pwr_en     (core_pwr_en[i]),
      .st_code    (code_flat[2*i +: 2])
    );
  end

endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk #(
  parameter int NCORES = 4,
  parameter int AW     = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [AW-1:0]         bus_addr,
  input logic [31:0]           bus_rdata,
  input logic [NCORES-1:0]     pwr_en,
  input logic [NCORES-1:0]     wake_q,
  input logic [2*NCORES-1:0]   mode_flat,
  input logic [31:0]           dbg_q
);

  logic        hit;
  logic [31:0] stat_rsvd;

  always_comb begin
    hit = (bus_addr == AW'(12'h010)) || (bus_addr == AW'(12'h040)) ||
          (bus_addr == AW'(12'h180));
    for (int i = 0; i < NCORES; i++)
      if (bus_addr == AW'(12'h100 + 12'(i) * 12'h010)) hit = 1'b1;
    stat_rsvd = '1;
    for (int i = 0; i < NCORES; i++) stat_rsvd[4*i +: 2] = 2'b00;
  end

  for (genvar i = 0; i < NCORES; i++) begin : g_per_core
    // R2
    pwr_rise_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en[i]) |-> $past(wake_q[i]));
    // R6
    pwr_fall_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en[i]) |-> ($past(mode_flat[2*i +: 2]) == 2'd3));
    // R4
    wake_clear_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wake_q[i]) |-> pwr_en[i]);
  end

  // R10
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we && bus_addr == AW'(12'h180)) |=> $stable(dbg_q));
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !hit) |-> (bus_rdata == 32'd0));
  // R8
  stat_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == AW'(12'h040)) |-> ((bus_rdata & stat_rsvd) == 32'd0));

endmodule

bind core_pwr_seq core_pwr_seq_chk #(.NCORES(NCORES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pwr_en    (core_pwr_en),
  .wake_q    (wake_q),
  .mode_flat (mode_flat),
  .dbg_q     (dbg_q)
);

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;

  logic          clk, rst_n, bus_en, bus_we;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [N-1:0]  core_wfi, core_pwr_en;
  int            n_tests, n_fail;
  logic [31:0]   rv;

  core_pwr_seq #(.NCORES(N), .AW(12), .DLY(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_wfi(core_wfi), .core_pwr_en(core_pwr_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // caller sits at a falling edge; read does not advance time past a rising edge
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_wfi(input int c);
    core_wfi[c] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    core_wfi[c] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pwr_en", 32'(core_pwr_en), 32'h1);
    rd(12'h010, rv); chk("R1 wake", rv, 0);
    rd(12'h180, rv); chk("R1 dbg", rv, 0);
    for (int c = 0; c < N; c++) begin
      rd(12'h100 + 12'(c) * 12'h010, rv); chk("R1 mode", rv, 0);
    end
    rd(12'h040, rv); chk("R8 status at reset", rv, 32'h0000_3330);
  endtask

  task automatic t_wake_standby;
    wr(12'h010, 32'h2);
    wait_n(16);
    chk("R2 still off", 32'(core_pwr_en[1]), 0);
    rd(12'h010, rv); chk("R2 wake pending", rv, 32'h2);
    rd(12'h040, rv); chk("R8 code off in power-up", rv, 32'h0000_3330);
    wait_n(1);
    chk("R2 on", 32'(core_pwr_en[1]), 1);
    rd(12'h010, rv); chk("R2 wake cleared", rv, 0);
    rd(12'h040, rv); chk("R8 code on", rv, 32'h0000_3300);
  endtask

  task automatic t_wake_running;
    wr(12'h010, 32'h1);
    rd(12'h010, rv); chk("R3 set", rv, 32'h1);
    wait_n(1);
    rd(12'h010, rv); chk("R3 cleared", rv, 0);
    chk("R3 pwr unchanged", 32'(core_pwr_en), 32'h3);
  endtask

  task automatic t_zero_no_cancel;
    wr(12'h010, 32'h8);
    wr(12'h010, 32'h0);
    rd(12'h010, rv); chk("R4 pending kept", rv, 32'h8);
    wait_n(15);
    chk("R4 still off", 32'(core_pwr_en[3]), 0);
    wait_n(1);
    chk("R4 on", 32'(core_pwr_en[3]), 1);
    rd(12'h010, rv); chk("R4 cleared", rv, 0);
  endtask

  task automatic t_arm_wfi;
    wr(12'h110, 32'hFFFF_FFF1);
    rd(12'h110, rv); chk("R5 readback 1", rv, 32'h1);
    pulse_wfi(1);
    wait_n(20);
    chk("R7 unarmed wfi", 32'(core_pwr_en[1]), 1);
    wr(12'h110, 32'h3);
    rd(12'h110, rv); chk("R5 readback 3", rv, 32'h3);
    pulse_wfi(1);
    wait_n(15);
    chk("R6 still on", 32'(core_pwr_en[1]), 1);
    rd(12'h040, rv); chk("R8 code on in power-down", rv[7:4], 0);
    wait_n(1);
    chk("R6 off", 32'(core_pwr_en[1]), 0);
    rd(12'h040, rv); chk("R6 code 3", rv[7:4], 32'h3);
    rd(12'h110, rv); chk("R6 mode cleared", rv, 0);
  endtask

  task automatic t_wfi_standby;
    wr(12'h120, 32'h3);
    pulse_wfi(2);
    wait_n(20);
    chk("R7 off core stays off", 32'(core_pwr_en[2]), 0);
    rd(12'h120, rv); chk("R7 mode kept", rv, 32'h3);
    wr(12'h120, 32'h0);
  endtask

  task automatic t_overlap;
    wr(12'h010, 32'h2);
    wait_n(17);
    chk("R2 core1 back on", 32'(core_pwr_en[1]), 1);
    wr(12'h110, 32'h3);
    pulse_wfi(1);
    wait_n(4);
    wr(12'h010, 32'h2);
    wait_n(10);
    chk("R9 on during down", 32'(core_pwr_en[1]), 1);
    wait_n(1);
    chk("R9 fell on time", 32'(core_pwr_en[1]), 0);
    rd(12'h010, rv); chk("R9 wake held", rv, 32'h2);
    wait_n(16);
    chk("R9 still off", 32'(core_pwr_en[1]), 0);
    wait_n(1);
    chk("R9 back on", 32'(core_pwr_en[1]), 1);
    rd(12'h010, rv); chk("R9 wake cleared", rv, 0);
  endtask

  task automatic t_debug;
    wr(12'h180, 32'h0100_0000);
    rd(12'h180, rv);
    wr(12'h180, rv | 32'h0020_0000 | 32'h0008_0000);
    rd(12'h180, rv); chk("R10 rmw", rv, 32'h0128_0000);
    wr(12'h180, 32'hA5A5_5A5A);
    rd(12'h180, rv); chk("R10 exact", rv, 32'hA5A5_5A5A);
  endtask

  task automatic t_unmapped;
    logic [N-1:0] p0;
    p0 = core_pwr_en;
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h140, 32'hFFFF_FFFF);
    wr(12'h184, 32'hFFFF_FFFF);
    rd(12'h020, rv); chk("R11 read 0x20", rv, 0);
    rd(12'h140, rv); chk("R11 read 0x140", rv, 0);
    rd(12'h014, rv); chk("R11 read 0x14", rv, 0);
    rd(12'h010, rv); chk("R11 wake untouched", rv, 0);
    rd(12'h180, rv); chk("R11 dbg untouched", rv, 32'hA5A5_5A5A);
    for (int c = 0; c < N; c++) begin
      rd(12'h100 + 12'(c) * 12'h010, rv); chk("R11 mode untouched", rv, 0);
    end
    wait_n(20);
    chk("R11 pwr untouched", 32'(core_pwr_en), 32'(p0));
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; core_wfi = '0;
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_wake_standby();
    t_wake_running();
    t_zero_no_cancel();
    t_arm_wfi();
    t_wfi_standby();
    t_overlap();
    t_debug();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule